// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one address per beat. A memory controller loads a start column together with a burst-length code and an ordering select. The block then presents the first column in the next cycle and moves to the next column of the burst each time the controller pulses the advance strobe.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned window of that size. The column bits above the window never change. The offset inside the window follows one of two orderings. Sequential ordering counts up and wraps around the window. Interleave ordering XORs the starting offset with the beat number. A full-page burst walks linearly across the whole page, wrapping at the page end, until a stop pulse ends it. A full-page burst may only use sequential ordering. A request for an unknown length code, or for full-page with interleave ordering, raises an error flag and produces no valid beats.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are low and `col_o` is zero.
- R2: A `start_i` pulse, in the next cycle, puts `start_col_i` on `col_o` as beat 0 and raises `valid_o` when the mode is supported. `start_i` takes priority over `adv_i` and `stop_i`, and it restarts any burst in progress.
- R3: Codes 1, 2 and 3 on `bl_code_i` select 2, 4 and 8 beats. With `ilv_i` = 0, beat k uses in-window offset (s + k) mod L, where s is the start offset in the low bits. The bits above the window keep their start value.
- R4: With `ilv_i` = 1 and a fixed length, beat k uses offset s XOR k. The bits above the window keep their start value.
- R5: `last_o` is high exactly on beat L−1 of a fixed burst. An advance on that beat drops `valid_o` in the next cycle.
- R6: While a burst is valid and none of `adv_i`, `stop_i` or `start_i` is high, `col_o` and `valid_o` hold.
- R7: Code 7 with `ilv_i` = 0 is a full-page burst. Each advance adds one to `col_o`, wrapping from 2^COL_W−1 to 0, and `last_o` stays low.
- R8: `stop_i` ends a full-page burst, so `valid_o` is low in the next cycle. `stop_i` has no effect during a fixed burst.
- R9: Codes 0, 4, 5 and 6, and code 7 with `ilv_i` = 1, are unsupported. For these, `err_o` goes high and `valid_o` stays low in the next cycle. Both stay that way until a start with a supported mode.
- R10: `adv_i` while no burst is valid has no effect: `valid_o` and `last_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | COL_W | Start column address |
| bl_code_i | input | 3 | Burst-length code (1:2, 2:4, 3:8, 7:full page) |
| ilv_i | input | 1 | 0 sequential, 1 interleave ordering |
| adv_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | End a full-page burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | Current column is a beat of a burst |
| last_o | output | 1 | Current beat is the final one of a fixed burst |
| err_o | output | 1 | Last start requested an unsupported mode |

## Verification
Some rules are checked by the assertions on every cycle. An error and a valid beat never appear together, and the last flag only appears with a valid beat. A start loads its column, or flags an unsupported mode, one cycle later. An advance on the last beat closes the burst, and an idle cycle holds the address. The actual beat orderings, the page wrap and the fact that a stop is ignored during fixed bursts can only be shown by the bench's scenarios. Those scenarios compare each emitted column against an expected order.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
    localparam int OFF_W = 3;

    localparam logic [2:0] BLC_2    = 3'd1;
    localparam logic [2:0] BLC_4    = 3'd2;
    localparam logic [2:0] BLC_8    = 3'd3;
    localparam logic [2:0] BLC_PAGE = 3'd7;

    typedef struct packed {
        logic             ok;
        logic             full;
        logic [OFF_W-1:0] mask;
    } bl_dec_t;
endpackage

// File: rtl/burst_colgen_decode.sv
module burst_colgen_decode
    import burst_colgen_pkg::*;
(
    input  logic [2:0] bl_code_i,
    input  logic       ilv_i,
    output bl_dec_t    dec_o
);
    always_comb begin
        dec_o = '{ok: 1'b0, full: 1'b0, mask: '0};
        case (bl_code_i)
            BLC_2:    dec_o = '{ok: 1'b1, full: 1'b0, mask: 3'b001};
            BLC_4:    dec_o = '{ok: 1'b1, full: 1'b0, mask: 3'b011};
            BLC_8:    dec_o = '{ok: 1'b1, full: 1'b0, mask: 3'b111};
            BLC_PAGE: dec_o = '{ok: !ilv_i, full: 1'b1, mask: 3'b000};
            default:  dec_o = '{ok: 1'b0, full: 1'b0, mask: '0};
        endcase
    end
endmodule

// File: rtl/burst_colgen_offset.sv
module burst_colgen_offset
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [OFF_W-1:0] beat_i,
    input  logic [OFF_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] off;

    assign start_off = base_i[OFF_W-1:0];
    assign off = ilv_i ? (start_off ^ beat_i) : (start_off + beat_i);

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < OFF_W) begin : g_win
            assign col_o[i] = mask_i[i] ? off[i] : base_i[i];
        end else begin : g_hi
            assign col_o[i] = base_i[i];
        end
    end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             ilv_i,
    input  logic             adv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    typedef struct packed {
        logic             valid;
        logic             last;
        logic             err;
        logic             full;
        logic             ilv;
        logic [OFF_W-1:0] mask;
        logic [OFF_W-1:0] beat;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] col;
    } state_t;

    state_t           st_d, st_q;
    bl_dec_t          dec;
    logic [OFF_W-1:0] beat_nx;
    logic [COL_W-1:0] win_col;

    burst_colgen_decode u_dec (
        .bl_code_i (bl_code_i),
        .ilv_i     (ilv_i),
        .dec_o     (dec)
    );

    assign beat_nx = st_q.beat + 1'b1;

    burst_colgen_offset #(.COL_W(COL_W)) u_off (
        .base_i (st_q.base),
        .beat_i (beat_nx),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (win_col)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.err   = !dec.ok;
            st_d.valid = dec.ok;
            st_d.last  = 1'b0;
            st_d.full  = dec.full;
            st_d.ilv   = ilv_i;
            st_d.mask  = dec.mask;
            st_d.beat  = '0;
            st_d.base  = start_col_i;
            st_d.col   = start_col_i;
        end else if (st_q.valid) begin
            if (st_q.full) begin
                if (stop_i) begin
                    st_d.valid = 1'b0;
                end else if (adv_i) begin
                    st_d.col = st_q.col + 1'b1;
                end
            end else if (adv_i) begin
                if (st_q.last) begin
                    st_d.valid = 1'b0;
                    st_d.last  = 1'b0;
                end else begin
                    st_d.beat = beat_nx;
                    st_d.col  = win_col;
                    st_d.last = (beat_nx == st_q.mask);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.valid;
    assign last_o  = st_q.last;
    assign err_o   = st_q.err;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       bl_code_i,
    input logic             ilv_i,
    input logic             adv_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    logic bad_mode;
    assign bad_mode = (bl_code_i == 3'd0) || (bl_code_i == 3'd4) ||
                      (bl_code_i == 3'd5) || (bl_code_i == 3'd6) ||
                      ((bl_code_i == 3'd7) && ilv_i);

    // R9
    err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && valid_o));

    // R5
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R9
    bad_mode_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && bad_mode) |=> (err_o && !valid_o));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !bad_mode) |=> (valid_o && col_o == $past(start_col_i)));

    // R5
    last_adv_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !start_i) |=> !valid_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !adv_i && !start_i && !stop_i) |=> (valid_o && $stable(col_o)));
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_colgen_tb.sv
`timescale 1ns/1ps
module burst_colgen_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       bl_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             adv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) u_dut (.*);

    // {code, ilv, start column, beats, offset of beat k in nibble k}
    localparam logic [49:0] VEC [0:6] = '{
        {3'd2, 1'b0, 10'h0A6, 4'd4, 32'h0000_1032},
        {3'd3, 1'b1, 10'h3F5, 4'd8, 32'h2301_6745},
        {3'd1, 1'b0, 10'h001, 4'd2, 32'h0000_0001},
        {3'd1, 1'b1, 10'h100, 4'd2, 32'h0000_0010},
        {3'd3, 1'b0, 10'h16B, 4'd8, 32'h2107_6543},
        {3'd2, 1'b1, 10'h203, 4'd4, 32'h0000_0123},
        {3'd3, 1'b1, 10'h002, 4'd8, 32'h5476_1032}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go(input logic [2:0] code, input logic ilv, input logic [COL_W-1:0] col);
        start_i = 1'b1; bl_code_i = code; ilv_i = ilv; start_col_i = col;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic step_adv();
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", valid_o, 0);
        chk("R1 last", last_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 col", col_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: advance while idle
        step_adv(); step_adv();
        chk("R10 valid", valid_o, 0);
        chk("R10 last", last_o, 0);

        // table walk: R3 sequential, R4 interleave, R5 last flag, R6 hold
        for (int v = 0; v < 7; v++) begin
            logic [2:0]       code;
            logic             ilv;
            logic [COL_W-1:0] sc;
            logic [3:0]       len;
            logic [31:0]      offs;
            logic [COL_W-1:0] hi;
            string            tag;
            {code, ilv, sc, len, offs} = VEC[v];
            hi  = sc & ~COL_W'(len - 1);
            tag = ilv ? "R4" : "R3";
            go(code, ilv, sc);
            chk("R2 beat0 col", col_o, sc);
            chk("R2 valid", valid_o, 1);
            chk("R5 last beat0", last_o, 0);
            for (int k = 1; k < len; k++) begin
                step_adv();
                chk(tag, col_o, hi | COL_W'(offs[4*k +: 4]));
                chk("R5 last", last_o, (k == len - 1));
                if (v == 1 && k == 3) begin
                    @(negedge clk);
                    chk("R6 hold col", col_o, hi | COL_W'(offs[15:12]));
                    chk("R6 hold valid", valid_o, 1);
                end
            end
            step_adv();
            chk("R5 end valid", valid_o, 0);
        end

        // R7: full page with wrap
        go(3'd7, 1'b0, 10'h3FE);
        chk("R7 col0", col_o, 10'h3FE);
        step_adv();
        chk("R7 col1", col_o, 10'h3FF);
        step_adv();
        chk("R7 wrap", col_o, 10'h000);
        chk("R7 last", last_o, 0);
        @(negedge clk);
        chk("R6 page hold", col_o, 10'h000);
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        chk("R8 stop page", valid_o, 0);

        // R8: stop ignored on fixed burst
        go(3'd2, 1'b0, 10'h005);
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        chk("R8 fixed valid", valid_o, 1);
        chk("R8 fixed col", col_o, 10'h005);
        step_adv();
        chk("R3 after stop", col_o, 10'h006);

        // R2: restart mid-burst with simultaneous advance
        adv_i = 1'b1;
        go(3'd3, 1'b0, 10'h200);
        adv_i = 1'b0;
        chk("R2 restart col", col_o, 10'h200);
        chk("R2 restart last", last_o, 0);

        // R9: unsupported modes
        go(3'd7, 1'b1, 10'h010);
        chk("R9 page ilv err", err_o, 1);
        chk("R9 page ilv valid", valid_o, 0);
        go(3'd5, 1'b0, 10'h010);
        chk("R9 code5 err", err_o, 1);
        step_adv();
        chk("R9 adv valid", valid_o, 0);
        chk("R9 err held", err_o, 1);
        go(3'd1, 1'b0, 10'h00F);
        chk("R9 clear err", err_o, 0);
        chk("R9 good valid", valid_o, 1);
        chk("R2 col", col_o, 10'h00F);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule